// File: doc/BRIEF.md
# Strobed ADC Host Sequencer

This block sits on the host side of a successive-approximation converter that uses a strobed control interface. A chip-select line, a read/convert strobe and a high-byte enable go out to the converter, and a busy line comes back from it. When a start request arrives, the sequencer selects the converter and holds the selection for a setup window. It then drives the strobe low for a fixed number of cycles. The falling edge of the strobe starts the conversion.

After the strobe, the sequencer waits for busy to fall and then rise again. It then reads the result as one 12-bit word, or as two bytes when byte mode is chosen. The result is presented with a one-cycle valid pulse. Busy passes through a synchronizer first. Consecutive conversion starts are kept at least a minimum number of cycles apart. A converter that never reports busy is detected by a timeout, which flags an error and releases the bus.

All timing limits are parameters in clock cycles. Each is rounded up from the converter's nanosecond limit: 40 ns for the strobe low time, 25 ns for the setup and 3 µs for the start-to-start spacing.

Top module: `hostadc_ctrl`

## Requirements
- R1: While reset is held and after it is released, `adc_cs_n`=1, `adc_rc`=1, `adc_hbe`=0, `result_valid`=0 and `timeout_err`=0 until a start request is made.
- R2: Before every falling edge of `adc_rc`, `adc_cs_n` has been 0 with `adc_rc` high for at least `SETUP_CYC` cycles. `adc_hbe` is 0 at the edge, and neither `adc_cs_n` nor `adc_hbe` changes while `adc_rc` is low.
- R3: Each low pulse on `adc_rc` lasts exactly `PULSE_CYC` clock cycles.
- R4: Two falling edges of `adc_rc` are never closer than `INTERVAL_CYC` cycles. When a request is waiting only on this spacing, the next edge comes exactly `INTERVAL_CYC` cycles after the previous one.
- R5: A read happens only after the synchronized busy has gone low and then high again. During a read, `adc_cs_n`=0 and `adc_rc`=1. In word mode there is one read with `adc_hbe`=0, and `result` = `adc_data[11:0]`.
- R6: In byte mode there are two reads. The first has `adc_hbe`=0 and supplies `result[7:0]` from `adc_data[7:0]`. The second has `adc_hbe`=1 and supplies `result[11:8]` from `adc_data[3:0]`. All other data bits are ignored in both reads.
- R7: Each completed conversion raises `result_valid` for exactly one cycle, and `result` holds the new value in that cycle.
- R8: If the synchronized busy is not seen low within `TIMEOUT_CYC` cycles after `adc_rc` returns high, `timeout_err` pulses for one cycle together with `adc_cs_n`=1. No `result_valid` follows for that attempt, and later requests are served normally.
- R9: A start request made during a conversion, or during the spacing window, is held and served afterwards. Any number of requests made while one is already pending merge into a single extra conversion.
- R10: `byte_mode` is sampled when a request is accepted. Changing it later has no effect on the conversion already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle conversion request |
| byte_mode | input | 1 | 1: two byte reads, 0: one word read |
| adc_busy | input | 1 | Converter busy, low while converting (asynchronous) |
| adc_data | input | DW | Converter data lines |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rc | output | 1 | Read/convert strobe; a falling edge starts a conversion |
| adc_hbe | output | 1 | High-byte enable for the second byte read |
| result | output | DW | Last converted value |
| result_valid | output | 1 | One-cycle pulse when `result` is new |
| timeout_err | output | 1 | One-cycle pulse when busy never fell |

## Verification
The bound checker watches the pin timing on every cycle, using its own counters:
- the exact strobe low width;
- the select setup before each strobe edge, and the stability of select and byte enable while the strobe is low;
- the minimum spacing between strobe edges;
- the single-cycle valid and error pulses;
- byte enable rising only during a read.

The scenarios against a converter model in the bench are the only place to show the rest:
- data assembly in both modes, including data bits that must be ignored;
- the exact spacing when a request is held;
- the merging of repeated requests;
- the sampling of the mode at acceptance;
- recovery after a timeout.

// File: rtl/hostadc_pkg.sv
package hostadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_READ_LO,
    ST_READ_HI,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic rc;
    logic hbe;
  } pin_t;

  // Pin levels driven in each sequencer state
  function automatic pin_t pins_for(seq_state_e s);
    pin_t p;
    case (s)
      ST_IDLE, ST_DONE: p = '{cs_n: 1'b1, rc: 1'b1, hbe: 1'b0};
      ST_PULSE:         p = '{cs_n: 1'b0, rc: 1'b0, hbe: 1'b0};
      ST_READ_HI:       p = '{cs_n: 1'b0, rc: 1'b1, hbe: 1'b1};
      default:          p = '{cs_n: 1'b0, rc: 1'b1, hbe: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hostadc_sync.sv
module hostadc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hostadc_downcnt.sv
module hostadc_downcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/hostadc_ctrl.sv
module hostadc_ctrl
  import hostadc_pkg::*;
#(
  parameter int DW           = 12,
  parameter int PULSE_CYC    = 4,
  parameter int SETUP_CYC    = 3,
  parameter int INTERVAL_CYC = 300,
  parameter int TIMEOUT_CYC  = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          byte_mode,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_data,
  output logic          adc_cs_n,
  output logic          adc_rc,
  output logic          adc_hbe,
  output logic [DW-1:0] result,
  output logic          result_valid,
  output logic          timeout_err
);
  localparam int LO_W   = 8;
  localparam int HI_W   = DW - LO_W;
  localparam int PH_MAX = (TIMEOUT_CYC > PULSE_CYC)
                          ? ((TIMEOUT_CYC > SETUP_CYC) ? TIMEOUT_CYC : SETUP_CYC)
                          : ((PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int IV_W   = $clog2(INTERVAL_CYC + 1);

  seq_state_e       state_q, state_d;
  logic             busy_s;
  logic             pend_q, mode_q, launch;
  logic             ph_load, ph_zero, iv_load, iv_zero, tmo;
  logic [PH_W-1:0]  ph_val;
  logic [LO_W-1:0]  lo_byte_q;
  logic [DW-1:0]    result_q;
  pin_t             pins_q;
  logic             valid_q, err_q;

  hostadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
    .clk(clk), .rst(rst), .d(adc_busy), .q(busy_s)
  );

  hostadc_downcnt #(.CW(PH_W)) u_phase_tmr (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  hostadc_downcnt #(.CW(IV_W)) u_space_tmr (
    .clk(clk), .rst(rst), .load(iv_load),
    .load_val(IV_W'(INTERVAL_CYC - 1)), .zero(iv_zero)
  );

  assign launch = (state_q == ST_IDLE) && pend_q;

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    iv_load = 1'b0;
    tmo     = 1'b0;
    case (state_q)
      ST_IDLE: if (pend_q) begin
        state_d = ST_SETUP;
        ph_load = 1'b1;
        ph_val  = PH_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (ph_zero && iv_zero) begin
        state_d = ST_PULSE;
        ph_load = 1'b1;
        ph_val  = PH_W'(PULSE_CYC - 1);
        iv_load = 1'b1;
      end
      ST_PULSE: if (ph_zero) begin
        state_d = ST_WAIT_LO;
        ph_load = 1'b1;
        ph_val  = PH_W'(TIMEOUT_CYC - 1);
      end
      ST_WAIT_LO: begin
        if (!busy_s) state_d = ST_WAIT_HI;
        else if (ph_zero) begin
          state_d = ST_IDLE;
          tmo     = 1'b1;
        end
      end
      ST_WAIT_HI: if (busy_s) state_d = ST_READ_LO;
      ST_READ_LO: state_d = mode_q ? ST_READ_HI : ST_DONE;
      ST_READ_HI: state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      mode_q    <= 1'b0;
      lo_byte_q <= '0;
      result_q  <= '0;
      pins_q    <= pins_for(ST_IDLE);
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= start_req | (pend_q & ~launch);
      if (launch) mode_q <= byte_mode;
      if (state_q == ST_READ_LO) begin
        if (mode_q) lo_byte_q <= adc_data[LO_W-1:0];
        else        result_q  <= adc_data;
      end
      if (state_q == ST_READ_HI)
        result_q <= {adc_data[HI_W-1:0], lo_byte_q};
      pins_q  <= pins_for(state_d);
      valid_q <= (state_d == ST_DONE);
      err_q   <= tmo;
    end
  end

  assign adc_cs_n     = pins_q.cs_n;
  assign adc_rc       = pins_q.rc;
  assign adc_hbe      = pins_q.hbe;
  assign result       = result_q;
  assign result_valid = valid_q;
  assign timeout_err  = err_q;
endmodule

// File: rtl/hostadc_ctrl_chk.sv
module hostadc_ctrl_chk #(
  parameter int PULSE_CYC    = 4,
  parameter int SETUP_CYC    = 3,
  parameter int INTERVAL_CYC = 300
) (
  input logic clk,
  input logic rst,
  input logic adc_cs_n,
  input logic adc_rc,
  input logic adc_hbe,
  input logic result_valid,
  input logic timeout_err
);
  logic [15:0] low_cnt, sel_cnt, gap_cnt;
  logic        seen_fall, rc_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      sel_cnt   <= '0;
      gap_cnt   <= '0;
      seen_fall <= 1'b0;
      rc_prev   <= 1'b1;
    end else begin
      rc_prev <= adc_rc;
      low_cnt <= adc_rc ? 16'd0 : low_cnt + 16'd1;
      if (adc_cs_n)     sel_cnt <= '0;
      else if (adc_rc)  sel_cnt <= (sel_cnt == 16'hFFFF) ? sel_cnt : sel_cnt + 16'd1;
      if (rc_prev && !adc_rc) begin
        gap_cnt   <= 16'd1;
        seen_fall <= 1'b1;
      end else if (gap_cnt != 16'hFFFF) begin
        gap_cnt <= gap_cnt + 16'd1;
      end
    end
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_rc) |-> low_cnt == 16'(PULSE_CYC));

  // R2
  setup_window_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_rc) |-> (!adc_cs_n && !adc_hbe && sel_cnt >= 16'(SETUP_CYC)));

  // R2
  hold_while_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!adc_rc && $past(!adc_rc)) |-> ($stable(adc_cs_n) && $stable(adc_hbe)));

  // R4
  start_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_rc) && seen_fall) |-> gap_cnt >= 16'(INTERVAL_CYC));

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R8
  timeout_release_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (adc_cs_n && !result_valid));

  // R8
  timeout_single_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err);

  // R6
  hbe_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_hbe) |-> (adc_rc && !adc_cs_n));
endmodule

bind hostadc_ctrl hostadc_ctrl_chk #(
  .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC), .INTERVAL_CYC(INTERVAL_CYC)
) u_chk (
  .clk(clk), .rst(rst), .adc_cs_n(adc_cs_n), .adc_rc(adc_rc),
  .adc_hbe(adc_hbe), .result_valid(result_valid), .timeout_err(timeout_err)
);

// File: tb/hostadc_ctrl_bench.sv
module hostadc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 12;
  localparam int PULSE      = 3;
  localparam int SETUP      = 2;
  localparam int INTERVAL   = 40;
  localparam int TIMEOUT    = 10;
  localparam int CONV       = 8;
  localparam int NVEC       = 6;
  // {byte_mode, code}
  localparam logic [12:0] VEC [NVEC] = '{13'h0000, 13'h0FFF, 13'h0A5C,
                                         13'h1123, 13'h1FFF, 13'h1800};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0, byte_mode = 1'b0;
  logic adc_busy;
  logic [DW-1:0] adc_data;
  logic adc_cs_n, adc_rc, adc_hbe, result_valid, timeout_err;
  logic [DW-1:0] result;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // converter model
  logic [DW-1:0] code_in = '0, code_lat = '0;
  logic mdl_byte = 1'b0, dead = 1'b0, busy_m = 1'b1, rc_q = 1'b1;
  int   cd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostadc_ctrl #(.DW(DW), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP),
    .INTERVAL_CYC(INTERVAL), .TIMEOUT_CYC(TIMEOUT), .SYNC_STAGES(2)) u_hostadc_ctrl (
    .clk(clk), .rst(rst), .start_req(start_req), .byte_mode(byte_mode),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_cs_n(adc_cs_n),
    .adc_rc(adc_rc), .adc_hbe(adc_hbe), .result(result),
    .result_valid(result_valid), .timeout_err(timeout_err));

  always @(posedge clk) begin
    rc_q <= adc_rc;
    if (rst) begin
      busy_m <= 1'b1; cd <= 0;
    end else if (rc_q && !adc_rc && !adc_cs_n && !adc_hbe && busy_m && !dead) begin
      code_lat <= code_in; busy_m <= 1'b0; cd <= CONV;
    end else if (cd != 0) begin
      cd <= cd - 1;
      if (cd == 1) busy_m <= 1'b1;
    end
  end
  assign adc_busy = busy_m;
  assign adc_data = (!adc_cs_n && adc_rc && busy_m)
                    ? (mdl_byte ? (adc_hbe ? {8'hA5, code_lat[11:8]} : {4'hC, code_lat[7:0]})
                                : code_lat)
                    : '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin monitor at falling edges
  int cyc = 0, lowc = 0, selc = 0, last_fall = -1, last_gap = 0;
  int fall_cnt = 0, valid_cnt = 0, err_cnt = 0;
  logic rc_s = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (result_valid) valid_cnt++;
      if (timeout_err) err_cnt++;
      if (rc_s && !adc_rc) begin
        fall_cnt++;
        check("R2 setup cycles", 32'(selc >= SETUP), 1);
        check("R2 hbe at edge", {31'd0, adc_hbe}, 0);
        if (last_fall >= 0) begin
          last_gap = cyc - last_fall;
          check("R4 min spacing", 32'(last_gap >= INTERVAL), 1);
        end
        last_fall = cyc;
      end
      if (!rc_s && adc_rc) check("R3 low width", 32'(lowc), 32'(PULSE));
      lowc = adc_rc ? 0 : lowc + 1;
      if (adc_cs_n) selc = 0; else if (adc_rc) selc++;
      rc_s = adc_rc;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic wait_valid(input string req, input logic [DW-1:0] exp);
    int k = 0;
    while (!result_valid && k < 300) begin @(negedge clk); k++; end
    check(req, {31'd0, result_valid}, 1);
    check(req, 32'(result), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 cs_n", {31'd0, adc_cs_n}, 1);
    check("R1 rc", {31'd0, adc_rc}, 1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 cs_n idle", {31'd0, adc_cs_n}, 1);
    check("R1 rc idle", {31'd0, adc_rc}, 1);
    check("R1 hbe idle", {31'd0, adc_hbe}, 0);
    check("R1 valid idle", {31'd0, result_valid}, 0);
    check("R1 err idle", {31'd0, timeout_err}, 0);

    // R5 word reads and R6 byte reads from the vector table
    for (int i = 0; i < NVEC; i++) begin
      code_in = VEC[i][11:0];
      mdl_byte = VEC[i][12];
      byte_mode = VEC[i][12];
      pulse_start();
      wait_valid(VEC[i][12] ? "R6 byte result" : "R5 word result", VEC[i][11:0]);
      @(negedge clk);
      check("R7 valid one cycle", {31'd0, result_valid}, 0);
      check("R7 result held", 32'(result), 32'(VEC[i][11:0]));
    end

    // R10: mode changed after acceptance has no effect
    code_in = 12'h9E7; mdl_byte = 1'b1; byte_mode = 1'b1;
    pulse_start();
    while (adc_rc) @(negedge clk);
    byte_mode = 1'b0;
    wait_valid("R10 mode latched", 12'h9E7);
    repeat (INTERVAL) @(negedge clk);

    // R9 pending during conversion + R4 exact spacing
    mdl_byte = 1'b0; byte_mode = 1'b0; code_in = 12'h3C1;
    valid_cnt = 0;
    begin
      int f0 = fall_cnt;
      pulse_start();
      while (fall_cnt == f0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (2) @(negedge clk);
    pulse_start();
    repeat (3 * INTERVAL) @(negedge clk);
    check("R9 held requests merged", 32'(valid_cnt), 2);
    check("R4 exact spacing", 32'(last_gap), 32'(INTERVAL));
    check("R9 result", 32'(result), 32'h3C1);

    // R8 timeout
    dead = 1'b1; valid_cnt = 0; err_cnt = 0;
    pulse_start();
    repeat (INTERVAL + 30) @(negedge clk);
    check("R8 error pulse", 32'(err_cnt), 1);
    check("R8 no valid", 32'(valid_cnt), 0);
    check("R8 bus released", {31'd0, adc_cs_n}, 1);
    dead = 1'b0; code_in = 12'h5AA;
    pulse_start();
    wait_valid("R8 recovery", 12'h5AA);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule